// File: doc/BRIEF.md
# Two-Wire Serial Programming Sequencer

This block is the host side of a two-wire in-circuit programming link. A local agent hands it one operation at a time (enter programming mode, leave it, load a word, read a word, step the target address, or write a word). The sequencer then drives the supply and programming-voltage enables in a fixed order. It toggles the serial clock, shifts command and data bits out, and releases the data line to capture read data. Every gap the target needs between transfers is inserted automatically.

Every timing figure is a parameter counted in system clocks. These cover the clock high and low phases, the gap after a command or data segment, the programming time, the discharge time after programming, and the supply settling time. A write runs as one request: load, begin, programming wait, end, and discharge. Because of this, a begin is never issued without a load in front of it.

Top module: `prog_seq`

## Requirements
- R1: Out of reset, busy_o and done_o are 0, both enables are 0, sclk_o and sdat_o are 0, and sdat_oe_o is 1 (line driven low).
- R2: Enter (op 0) raises vdd_en_o first and raises vpp_en_o no sooner than PWR_CYC clocks later. Both serial lines stay driven low and no serial clock is produced.
- R3: Exit (op 1) drops vpp_en_o first and drops vdd_en_o no sooner than PWR_CYC clocks later. Both serial lines are driven low while this happens.
- R4: Each command is six serial clocks, least significant bit first. Every clock is high for HI_CYC and low for LO_CYC. sdat_o changes only at a rising edge, so it is steady across each falling edge. The codes are load 0x02, read 0x04, increment 0x06, begin 0x08 and end 0x0E.
- R5: The first rising clock of the next transfer comes at least GAP_CYC clocks after the last falling clock of a command. This holds whether the next transfer is a data segment or another command.
- R6: Load (op 2) sends command 0x02 and then a 16-clock segment: a 0 start bit, the 14 bits of req_data_i least significant first, and a 0 stop bit.
- R7: Read (op 3) sends command 0x04 and then releases the line (sdat_oe_o = 0) for the 16-clock segment. It samples sdat_i just before the falling edges of clocks 2 to 15 as bits 0 to 13. The result is on rd_data_o when done_o pulses.
- R8: Write (op 5) sends a full load of req_data_i, then begin 0x08. It waits at least PROG_CYC clocks from the last falling edge of begin to the first rising edge of end 0x0E. It then waits at least DIS_CYC clocks from the last falling edge of end before done_o.
- R9: busy_o is 1 from the clock after a request is accepted until the operation ends. done_o is a one-clock pulse in the first clock that busy_o is 0 again.
- R10: A request made while busy_o is 1, or one with an op code of 6 or 7, is ignored: no clocks, no done pulse, no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when busy_o is 0 |
| req_op_i | input | 3 | Operation code (0 enter, 1 exit, 2 load, 3 read, 4 increment, 5 write) |
| req_data_i | input | 14 | Word for load and write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| rd_data_o | output | 14 | Word captured by the last read |
| sclk_o | output | 1 | Serial clock to target |
| sdat_o | output | 1 | Serial data to target |
| sdat_oe_o | output | 1 | Data line output enable (0 = released) |
| sdat_i | input | 1 | Serial data from target |
| vdd_en_o | output | 1 | Target supply enable |
| vpp_en_o | output | 1 | Programming voltage enable |

## Verification
A sequencer state that skips a step shows up at the serial pins within one transfer. A missing begin or end changes the captured bit count and command codes. A stuck wait state shows up as a hung busy_o, which the bench flags well inside its watchdog. Timer or phase-counter faults shorten a gap or a programming wait, and the edge-to-edge times measured at sclk_o expose them at the next rising edge. Wrong enable sequencing becomes visible the moment the second supply enable moves.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  typedef enum logic [2:0] {
    OP_ENTER = 3'd0,
    OP_EXIT  = 3'd1,
    OP_LOAD  = 3'd2,
    OP_READ  = 3'd3,
    OP_INCR  = 3'd4,
    OP_WRITE = 3'd5
  } op_e;

  localparam int CMD_BITS  = 6;
  localparam int DATA_BITS = 14;
  localparam int SEG_BITS  = DATA_BITS + 2;

  // target decodes these, LSb shifted first
  localparam logic [CMD_BITS-1:0] CMD_LOAD  = 6'h02;
  localparam logic [CMD_BITS-1:0] CMD_READ  = 6'h04;
  localparam logic [CMD_BITS-1:0] CMD_INCR  = 6'h06;
  localparam logic [CMD_BITS-1:0] CMD_BEGIN = 6'h08;
  localparam logic [CMD_BITS-1:0] CMD_END   = 6'h0E;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ON_VDD, ST_ON_VPP, ST_OFF_VPP, ST_OFF_VDD,
    ST_CMD, ST_CMD_GAP, ST_DATA, ST_DATA_GAP,
    ST_BEGIN, ST_PROG, ST_END, ST_DISCH
  } st_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic op_known(logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic logic [CMD_BITS-1:0] op_cmd(op_e op);
    case (op)
      OP_READ: return CMD_READ;
      OP_INCR: return CMD_INCR;
      default: return CMD_LOAD;
    endcase
  endfunction
endpackage

// File: rtl/prog_seq_timer.sv
module prog_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/prog_seq_serial.sv
module prog_seq_serial #(
  parameter int HI_CYC   = 4,
  parameter int LO_CYC   = 4,
  parameter int MAX_BITS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         listen_i,
  input  logic [$clog2(MAX_BITS):0]    nbits_i,
  input  logic [MAX_BITS-1:0]          word_i,
  input  logic                         sdat_i,
  output logic                         sclk_o,
  output logic                         sdat_o,
  output logic                         oe_o,
  output logic                         done_o,
  output logic [MAX_BITS-1:0]          rx_o
);
  localparam int PH_W  = $clog2(prog_seq_pkg::max2(HI_CYC, LO_CYC) + 1);
  localparam int IDX_W = $clog2(MAX_BITS);

  typedef enum logic [1:0] {SH_IDLE, SH_HIGH, SH_LOW} sh_e;

  sh_e                 st_q;
  logic [PH_W-1:0]     ph_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W:0]      nbits_q;
  logic [MAX_BITS-1:0] sh_q;
  logic                last_bit;

  assign last_bit = ({1'b0, idx_q} == nbits_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SH_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      nbits_q <= '0;
      sh_q    <= '0;
      sclk_o  <= 1'b0;
      sdat_o  <= 1'b0;
      oe_o    <= 1'b1;
      done_o  <= 1'b0;
      rx_o    <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        SH_IDLE: begin
          if (start_i) begin
            st_q    <= SH_HIGH;
            ph_q    <= PH_W'(HI_CYC - 1);
            idx_q   <= '0;
            nbits_q <= nbits_i;
            sh_q    <= word_i;
            sclk_o  <= 1'b1;
            sdat_o  <= listen_i ? 1'b0 : word_i[0];
            oe_o    <= ~listen_i;
            rx_o    <= '0;
          end
        end
        SH_HIGH: begin
          if (ph_q == '0) begin
            st_q        <= SH_LOW;
            ph_q        <= PH_W'(LO_CYC - 1);
            sclk_o      <= 1'b0;
            rx_o[idx_q] <= sdat_i;   // sample at end of high phase
          end else begin
            ph_q <= ph_q - 1'b1;
          end
        end
        SH_LOW: begin
          if (ph_q != '0) begin
            ph_q <= ph_q - 1'b1;
          end else if (last_bit) begin
            st_q   <= SH_IDLE;
            done_o <= 1'b1;
            sdat_o <= 1'b0;
            oe_o   <= 1'b1;
          end else begin
            st_q   <= SH_HIGH;
            ph_q   <= PH_W'(HI_CYC - 1);
            idx_q  <= idx_q + 1'b1;
            sh_q   <= sh_q >> 1;
            sclk_o <= 1'b1;
            if (oe_o) sdat_o <= sh_q[1];
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prog_seq_ctrl.sv
module prog_seq_ctrl
  import prog_seq_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter int GAP_CYC  = 8,
  parameter int PROG_CYC = 100,
  parameter int DIS_CYC  = 50,
  parameter int PWR_CYC  = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [2:0]                req_op_i,
  input  logic [DATA_BITS-1:0]      req_data_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [DATA_BITS-1:0]      rd_data_o,
  output logic                      vdd_en_o,
  output logic                      vpp_en_o,
  output logic                      tmr_load_o,
  output logic [TMR_W-1:0]          tmr_val_o,
  input  logic                      tmr_zero_i,
  output logic                      ser_start_o,
  output logic                      ser_listen_o,
  output logic [$clog2(SEG_BITS):0] ser_nbits_o,
  output logic [SEG_BITS-1:0]       ser_word_o,
  input  logic                      ser_done_i,
  input  logic [SEG_BITS-1:0]       ser_rx_i
);
  localparam int NB_W = $clog2(SEG_BITS) + 1;

  st_e                  st_q, st_d;
  op_e                  op_q;
  logic [DATA_BITS-1:0] data_q;
  logic                 finish;
  logic                 accept;

  assign busy_o = (st_q != ST_IDLE);

  always_comb begin
    st_d         = st_q;
    finish       = 1'b0;
    accept       = 1'b0;
    tmr_load_o   = 1'b0;
    tmr_val_o    = '0;
    ser_start_o  = 1'b0;
    ser_listen_o = 1'b0;
    ser_nbits_o  = NB_W'(CMD_BITS);
    ser_word_o   = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid_i && op_known(req_op_i)) begin
          accept = 1'b1;
          case (op_e'(req_op_i))
            OP_ENTER: begin
              st_d = ST_ON_VDD; tmr_load_o = 1'b1; tmr_val_o = TMR_W'(PWR_CYC);
            end
            OP_EXIT: begin
              st_d = ST_OFF_VPP; tmr_load_o = 1'b1; tmr_val_o = TMR_W'(PWR_CYC);
            end
            default: begin
              st_d        = ST_CMD;
              ser_start_o = 1'b1;
              ser_word_o  = SEG_BITS'(op_cmd(op_e'(req_op_i)));
            end
          endcase
        end
      end
      ST_ON_VDD: if (tmr_zero_i) begin
        st_d = ST_ON_VPP; tmr_load_o = 1'b1; tmr_val_o = TMR_W'(PWR_CYC);
      end
      ST_ON_VPP:  if (tmr_zero_i) finish = 1'b1;
      ST_OFF_VPP: if (tmr_zero_i) begin
        st_d = ST_OFF_VDD; tmr_load_o = 1'b1; tmr_val_o = TMR_W'(PWR_CYC);
      end
      ST_OFF_VDD: if (tmr_zero_i) finish = 1'b1;
      ST_CMD: if (ser_done_i) begin
        st_d = ST_CMD_GAP; tmr_load_o = 1'b1; tmr_val_o = TMR_W'(GAP_CYC);
      end
      ST_CMD_GAP: if (tmr_zero_i) begin
        if (op_q == OP_INCR) begin
          finish = 1'b1;
        end else begin
          st_d         = ST_DATA;
          ser_start_o  = 1'b1;
          ser_nbits_o  = NB_W'(SEG_BITS);
          ser_listen_o = (op_q == OP_READ);
          ser_word_o   = (op_q == OP_READ) ? '0 : {1'b0, data_q, 1'b0};
        end
      end
      ST_DATA: if (ser_done_i) begin
        st_d = ST_DATA_GAP; tmr_load_o = 1'b1; tmr_val_o = TMR_W'(GAP_CYC);
      end
      ST_DATA_GAP: if (tmr_zero_i) begin
        if (op_q == OP_WRITE) begin
          st_d        = ST_BEGIN;
          ser_start_o = 1'b1;
          ser_word_o  = SEG_BITS'(CMD_BEGIN);
        end else begin
          finish = 1'b1;
        end
      end
      ST_BEGIN: if (ser_done_i) begin
        st_d = ST_PROG; tmr_load_o = 1'b1; tmr_val_o = TMR_W'(PROG_CYC);
      end
      ST_PROG: if (tmr_zero_i) begin
        st_d        = ST_END;
        ser_start_o = 1'b1;
        ser_word_o  = SEG_BITS'(CMD_END);
      end
      ST_END: if (ser_done_i) begin
        st_d = ST_DISCH; tmr_load_o = 1'b1; tmr_val_o = TMR_W'(DIS_CYC);
      end
      ST_DISCH: if (tmr_zero_i) finish = 1'b1;
      default: st_d = ST_IDLE;
    endcase
    if (finish) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_ENTER;
      data_q    <= '0;
      done_o    <= 1'b0;
      rd_data_o <= '0;
      vdd_en_o  <= 1'b0;
      vpp_en_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= finish;
      if (accept) begin
        op_q   <= op_e'(req_op_i);
        data_q <= req_data_i;
        if (op_e'(req_op_i) == OP_ENTER) vdd_en_o <= 1'b1;
        if (op_e'(req_op_i) == OP_EXIT)  vpp_en_o <= 1'b0;
      end
      if (st_q == ST_ON_VDD  && tmr_zero_i) vpp_en_o <= 1'b1;
      if (st_q == ST_OFF_VPP && tmr_zero_i) vdd_en_o <= 1'b0;
      if (st_q == ST_DATA && ser_done_i && op_q == OP_READ)
        rd_data_o <= ser_rx_i[DATA_BITS:1];
    end
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int HI_CYC   = 10,
  parameter int LO_CYC   = 10,
  parameter int GAP_CYC  = 100,
  parameter int PROG_CYC = 200000,
  parameter int DIS_CYC  = 10000,
  parameter int PWR_CYC  = 500
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [2:0]  req_op_i,
  input  logic [13:0] req_data_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [13:0] rd_data_o,
  output logic        sclk_o,
  output logic        sdat_o,
  output logic        sdat_oe_o,
  input  logic        sdat_i,
  output logic        vdd_en_o,
  output logic        vpp_en_o
);
  localparam int T_MAX = max2(max2(GAP_CYC, PROG_CYC), max2(DIS_CYC, PWR_CYC));
  localparam int TMR_W = $clog2(T_MAX + 1);
  localparam int NB_W  = $clog2(SEG_BITS) + 1;

  logic                tmr_load, tmr_zero;
  logic [TMR_W-1:0]    tmr_val;
  logic                ser_start, ser_listen, ser_done;
  logic [NB_W-1:0]     ser_nbits;
  logic [SEG_BITS-1:0] ser_word, ser_rx;

  prog_seq_ctrl #(
    .TMR_W(TMR_W), .GAP_CYC(GAP_CYC), .PROG_CYC(PROG_CYC),
    .DIS_CYC(DIS_CYC), .PWR_CYC(PWR_CYC)
  ) i_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_data_i,
    .busy_o, .done_o, .rd_data_o, .vdd_en_o, .vpp_en_o,
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .tmr_zero_i(tmr_zero),
    .ser_start_o(ser_start), .ser_listen_o(ser_listen),
    .ser_nbits_o(ser_nbits), .ser_word_o(ser_word),
    .ser_done_i(ser_done), .ser_rx_i(ser_rx)
  );

  prog_seq_timer #(.W(TMR_W)) i_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  prog_seq_serial #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .MAX_BITS(SEG_BITS)) i_serial (
    .clk_i, .rst_ni, .start_i(ser_start), .listen_i(ser_listen),
    .nbits_i(ser_nbits), .word_i(ser_word), .sdat_i,
    .sclk_o, .sdat_o, .oe_o(sdat_oe_o), .done_o(ser_done), .rx_o(ser_rx)
  );
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic sdat_o,
  input logic sdat_oe_o,
  input logic vdd_en_o,
  input logic vpp_en_o
);
  assert_vpp_needs_vdd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_en_o |-> vdd_en_o);

  assert_lines_low_on_supply_move_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(vdd_en_o) || $fell(vdd_en_o) || $rose(vpp_en_o) || $fell(vpp_en_o))
      |-> (!sclk_o && !sdat_o && sdat_oe_o));

  assert_data_steady_at_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sclk_o && !$rose(sclk_o)) || $fell(sclk_o)) |-> ($stable(sdat_o) && $stable(sdat_oe_o)));

  assert_clock_only_when_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> busy_o);

  assert_release_only_when_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdat_oe_o |-> busy_o);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_ends_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind prog_seq prog_seq_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .sclk_o(sclk_o), .sdat_o(sdat_o), .sdat_oe_o(sdat_oe_o),
  .vdd_en_o(vdd_en_o), .vpp_en_o(vpp_en_o)
);

// File: tb/test_prog_seq.sv
`timescale 1ns/1ps
module test_prog_seq;
  localparam int HI = 2, LO = 3, GAP = 5, PROG = 40, DIS = 20, PWR = 10;
  localparam realtime TCK = 8.0;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_op_i = '0;
  logic [13:0] req_data_i = '0;
  logic        busy_o, done_o, sclk_o, sdat_o, sdat_oe_o, vdd_en_o, vpp_en_o;
  logic [13:0] rd_data_o;
  logic        sdat_i = 1'b0;

  int checks = 0, fails = 0, done_cnt = 0, rise_cnt = 0;
  bit finished = 0;
  realtime rise_t[$], fall_t[$];
  bit      bits[$], oes[$];
  realtime vdd_up, vpp_up, vdd_dn, vpp_dn, done_t;
  logic [13:0] tgt_word = '0;
  bit tgt_en = 0;

  prog_seq #(.HI_CYC(HI), .LO_CYC(LO), .GAP_CYC(GAP), .PROG_CYC(PROG),
             .DIS_CYC(DIS), .PWR_CYC(PWR)) i_prog_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_data_i, .busy_o, .done_o,
    .rd_data_o, .sclk_o, .sdat_o, .sdat_oe_o, .sdat_i, .vdd_en_o, .vpp_en_o
  );

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) if (done_o) begin done_cnt++; done_t = $realtime; end
  always @(posedge vdd_en_o) vdd_up = $realtime;
  always @(posedge vpp_en_o) vpp_up = $realtime;
  always @(negedge vdd_en_o) vdd_dn = $realtime;
  always @(negedge vpp_en_o) vpp_dn = $realtime;

  // target model: drives read data from the 2nd data clock onward
  always @(posedge sclk_o) begin
    rise_t.push_back($realtime);
    rise_cnt++;
    if (tgt_en && rise_cnt >= 8 && rise_cnt <= 21) sdat_i = tgt_word[rise_cnt-8];
    else sdat_i = 1'b0;
  end
  always @(negedge sclk_o) begin
    fall_t.push_back($realtime);
    bits.push_back(sdat_o);
    oes.push_back(sdat_oe_o);
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rise_t.delete(); fall_t.delete(); bits.delete(); oes.delete();
    rise_cnt = 0;
  endtask

  function automatic int field(int lo, int n);
    int v = 0;
    for (int i = 0; i < n; i++) if (bits[lo+i]) v |= (1 << i);
    return v;
  endfunction

  function automatic int gap_cyc(realtime a, realtime b);
    return int'((b - a) / TCK);
  endfunction

  task automatic do_req(logic [2:0] op, logic [13:0] d);
    int start = done_cnt;
    int t = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op; req_data_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(busy_o === 1'b1, "R9 busy after accept", busy_o, 1);
    while (done_cnt == start && t < 20000) begin @(negedge clk_i); t++; end
    chk(done_cnt == start + 1, "R9 single done", done_cnt - start, 1);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R9 idle after done", busy_o, 0);
  endtask

  task automatic t_reset();
    chk(busy_o === 0 && done_o === 0, "R1 busy/done", {busy_o, done_o}, 0);
    chk(vdd_en_o === 0 && vpp_en_o === 0, "R1 enables", {vdd_en_o, vpp_en_o}, 0);
    chk(sclk_o === 0 && sdat_o === 0 && sdat_oe_o === 1, "R1 lines",
        {sclk_o, sdat_o, sdat_oe_o}, 1);
  endtask

  task automatic t_enter();
    clear_mon();
    do_req(3'd0, '0);
    chk(vdd_en_o && vpp_en_o, "R2 both on", {vdd_en_o, vpp_en_o}, 3);
    chk(gap_cyc(vdd_up, vpp_up) >= PWR, "R2 vpp after vdd", gap_cyc(vdd_up, vpp_up), PWR);
    chk(bits.size() == 0 && sdat_o == 0 && sdat_oe_o, "R2 lines held low", bits.size(), 0);
  endtask

  task automatic t_exit();
    clear_mon();
    do_req(3'd1, '0);
    chk(!vdd_en_o && !vpp_en_o, "R3 both off", {vdd_en_o, vpp_en_o}, 0);
    chk(gap_cyc(vpp_dn, vdd_dn) >= PWR, "R3 vdd after vpp", gap_cyc(vpp_dn, vdd_dn), PWR);
    chk(bits.size() == 0 && !sclk_o && !sdat_o && sdat_oe_o, "R3 lines low",
        bits.size(), 0);
  endtask

  task automatic t_load(logic [13:0] d);
    clear_mon();
    do_req(3'd2, d);
    chk(bits.size() == 22, "R6 clock count", bits.size(), 22);
    if (bits.size() == 22) begin
      chk(field(0, 6) == 'h02, "R4 load code", field(0, 6), 'h02);
      chk(!bits[6] && !bits[21], "R6 start/stop", {bits[6], bits[21]}, 0);
      chk(field(7, 14) == d, "R6 data", field(7, 14), d);
      chk(gap_cyc(fall_t[5], rise_t[6]) >= GAP, "R5 cmd to data gap",
          gap_cyc(fall_t[5], rise_t[6]), GAP);
      chk(gap_cyc(rise_t[0], fall_t[0]) == HI, "R4 high phase",
          gap_cyc(rise_t[0], fall_t[0]), HI);
      chk(gap_cyc(fall_t[0], rise_t[1]) == LO, "R4 low phase",
          gap_cyc(fall_t[0], rise_t[1]), LO);
    end
  endtask

  task automatic t_incr_pair();
    clear_mon();
    do_req(3'd4, '0);
    do_req(3'd4, '0);
    chk(bits.size() == 12, "R4 incr clocks", bits.size(), 12);
    if (bits.size() == 12) begin
      chk(field(0, 6) == 'h06 && field(6, 6) == 'h06, "R4 incr code", field(0, 6), 'h06);
      chk(gap_cyc(fall_t[5], rise_t[6]) >= GAP, "R5 cmd to cmd gap",
          gap_cyc(fall_t[5], rise_t[6]), GAP);
    end
  endtask

  task automatic t_read(logic [13:0] w);
    clear_mon();
    tgt_word = w; tgt_en = 1;
    do_req(3'd3, '0);
    tgt_en = 0;
    chk(bits.size() == 22, "R7 clock count", bits.size(), 22);
    if (bits.size() == 22) begin
      int rel = 0;
      for (int i = 6; i < 22; i++) if (!oes[i]) rel++;
      chk(field(0, 6) == 'h04, "R7 read code", field(0, 6), 'h04);
      chk(rel == 16 && oes[5], "R7 line released for segment", rel, 16);
    end
    chk(rd_data_o == w, "R7 read data", rd_data_o, w);
  endtask

  task automatic t_write(logic [13:0] d);
    clear_mon();
    do_req(3'd5, d);
    chk(bits.size() == 34, "R8 clock count", bits.size(), 34);
    if (bits.size() == 34) begin
      chk(field(0, 6) == 'h02 && field(7, 14) == d, "R8 load first", field(7, 14), d);
      chk(field(22, 6) == 'h08, "R8 begin code", field(22, 6), 'h08);
      chk(field(28, 6) == 'h0E, "R8 end code", field(28, 6), 'h0E);
      chk(gap_cyc(fall_t[27], rise_t[28]) >= PROG, "R8 program time",
          gap_cyc(fall_t[27], rise_t[28]), PROG);
      chk(gap_cyc(fall_t[33], done_t) >= DIS, "R8 discharge time",
          gap_cyc(fall_t[33], done_t), DIS);
      chk(gap_cyc(fall_t[21], rise_t[22]) >= GAP, "R5 data to begin gap",
          gap_cyc(fall_t[21], rise_t[22]), GAP);
    end
  endtask

  task automatic t_ignore();
    int start;
    clear_mon();
    start = done_cnt;
    // unknown op while idle
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 3'd6;
    @(negedge clk_i);
    req_op_i = 3'd7;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk(!busy_o && done_cnt == start && bits.size() == 0, "R10 unknown op",
        bits.size(), 0);
    // request while busy
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 3'd2; req_data_i = 14'h0F0F;
    @(negedge clk_i);
    req_op_i = 3'd4; req_data_i = 14'h3FFF;
    repeat (20) @(negedge clk_i);
    req_valid_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    repeat (10) @(negedge clk_i);
    chk(done_cnt == start + 1, "R10 one done", done_cnt - start, 1);
    chk(bits.size() == 22, "R10 no extra clocks", bits.size(), 22);
    if (bits.size() == 22)
      chk(field(7, 14) == 'h0F0F, "R10 data unchanged", field(7, 14), 'h0F0F);
  endtask

  initial begin
    #(TCK * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_enter();
    t_load(14'h2A55);
    t_load(14'h0001);
    t_incr_pair();
    t_read(14'h1C3B);
    t_read(14'h3FFF);
    t_write(14'h0ABC);
    t_ignore();
    t_exit();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule